// File: doc/BRIEF.md
# Symmetric Rank-k Update Mesh

This block is a square mesh of processing elements that updates the lower triangle of a symmetric result tile. Each processing element (PE) owns one element of the tile and keeps it in a local signed fixed-point accumulator. The host first loads the starting tile through a load port. It then starts a run with a column count and streams the columns of an input panel one vector per accepted cycle. When the run is finished, the block reads the tile back one element per cycle.

Each incoming column is placed on the per-row broadcast buses, and every PE in a row latches the value. On the following cycle the diagonal PEs send their own row values onto the per-column buses. As a result, every PE holds both its row element and its column element of the same column vector. Only PEs on or below the diagonal add the product of the two into their accumulators, so each column gives one rank-1 update.

As a side result, PE row r keeps the column-bus values it saw while column r was in flight. The mesh therefore also holds the transpose of the first columns of the panel, and this transpose is read out beside the tile. Columns may arrive with idle cycles between them. Two more cycles complete the last update before completion is flagged.

Top module: `mesh_rank_update`

## Requirements
- R1: After reset, `busy`, `done` and `rd_valid` are low.
- R2: A write on the load port while the block is idle sets element `ld_index` (row-major, index = row*N + column) to `ld_value`. A run with zero columns reads back exactly the loaded tile.
- R3: After a run of K columns, every element with row ≥ column equals its loaded value plus the sum over k of a_k[row]·a_k[column]. Element r of a column vector is `vec_data[r*OP_W +: OP_W]`, signed.
- R4: Elements with row < column keep their loaded value for the whole run.
- R5: At readout index row*N+c, `rd_trn` is element c of column number `row` when row < K. Otherwise it is 0, because the transpose store is cleared at each start.
- R6: `done` is high for exactly one cycle: the third cycle after the edge that accepts the last column. `rd_valid` is high on that cycle and on the N*N−1 cycles that follow, and the elements come out in row-major order.
- R7: While a run is in progress, a start request and writes on the load port are ignored. A vector offered while the block is idle is ignored.
- R8: Cycles with `vec_valid` low inside a run have no effect on the result.
- R9: `busy` rises on the cycle after an accepted start and falls after the last readout element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load-port write strobe |
| ld_index | input | $clog2(N*N) | Row-major element index |
| ld_value | input | ACC_W | Signed starting value |
| go | input | 1 | Start request (taken only when idle) |
| num_cols | input | K_W | Number of columns in the run |
| busy | output | 1 | Run or readout in progress |
| vec_valid | input | 1 | Column vector present |
| vec_data | input | N*OP_W | Column vector, element r at r*OP_W |
| done | output | 1 | Marks the first readout cycle |
| rd_valid | output | 1 | Readout element valid |
| rd_acc | output | ACC_W | Tile element at the current readout index |
| rd_trn | output | OP_W | Transpose-store element at the same index |

## Verification
The checker asserts on every cycle that `done` is a single-cycle pulse that falls inside the readout window, that the readout window has no gaps, that no readout happens while the block is idle, and that every accumulator above the diagonal keeps its value through a run. The arithmetic itself can only be shown by the bench scenarios, which compare each readout element against a behavioural model. These scenarios cover the tile sums, the contents of the transpose store, the exact latency from the last column to `done`, and the fact that stalls and stray load, start or vector requests leave the result unchanged.

// File: rtl/mesh_pkg.sv
package mesh_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DUMP  = 2'd3
    } mesh_state_e;
endpackage

// File: rtl/mesh_ctrl.sv
module mesh_ctrl
    import mesh_pkg::*;
#(
    parameter int N   = 4,
    parameter int K_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       go,
    input  logic [K_W-1:0]             num_cols,
    input  logic                       vec_valid,
    output logic                       accept,
    output logic                       stage1,
    output logic                       stage2,
    output logic [K_W-1:0]             stage2_k,
    output logic                       clr_trn,
    output logic                       load_en,
    output logic                       busy,
    output logic                       done,
    output logic                       rd_valid,
    output logic [$clog2(N*N)-1:0]     rd_idx
);
    localparam int IDX_W = $clog2(N*N);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N*N-1);

    typedef struct packed {
        mesh_state_e      st;
        logic [K_W-1:0]   kcnt;
        logic [K_W-1:0]   klim;
        logic [K_W-1:0]   k1;
        logic [K_W-1:0]   k2;
        logic             v1;
        logic             v2;
        logic [IDX_W-1:0] idx;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic [K_W-1:0] kcnt_inc;

    always_comb begin
        ctrl_d   = ctrl_q;
        kcnt_inc = ctrl_q.kcnt + K_W'(1);
        accept   = (ctrl_q.st == ST_RUN) && vec_valid;
        // operand pipeline: bus stage then PE operand stage
        ctrl_d.v1 = accept;
        ctrl_d.k1 = ctrl_q.kcnt;
        ctrl_d.v2 = ctrl_q.v1;
        ctrl_d.k2 = ctrl_q.k1;
        case (ctrl_q.st)
            ST_IDLE: begin
                if (go) begin
                    ctrl_d.klim = num_cols;
                    ctrl_d.kcnt = '0;
                    ctrl_d.st   = (num_cols == '0) ? ST_DRAIN : ST_RUN;
                end
            end
            ST_RUN: begin
                if (accept) begin
                    ctrl_d.kcnt = kcnt_inc;
                    if (kcnt_inc == ctrl_q.klim) ctrl_d.st = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (!ctrl_q.v1 && !ctrl_q.v2) begin
                    ctrl_d.st  = ST_DUMP;
                    ctrl_d.idx = '0;
                end
            end
            default: begin
                ctrl_d.idx = ctrl_q.idx + IDX_W'(1);
                if (ctrl_q.idx == LAST_IDX) ctrl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign stage1   = ctrl_q.v1;
    assign stage2   = ctrl_q.v2;
    assign stage2_k = ctrl_q.k2;
    assign clr_trn  = (ctrl_q.st == ST_IDLE) && go;
    assign load_en  = (ctrl_q.st == ST_IDLE);
    assign busy     = (ctrl_q.st != ST_IDLE);
    assign rd_valid = (ctrl_q.st == ST_DUMP);
    assign done     = (ctrl_q.st == ST_DUMP) && (ctrl_q.idx == '0);
    assign rd_idx   = ctrl_q.idx;
endmodule

// File: rtl/mesh_pe.sv
module mesh_pe #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40,
    parameter int ROW   = 0,
    parameter int COL   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pl_we,
    input  logic [ACC_W-1:0] pl_data,
    input  logic             clr_trn,
    input  logic             ld_op,
    input  logic [OP_W-1:0]  row_bus,
    input  logic [OP_W-1:0]  col_bus,
    input  logic             upd,
    input  logic             cap_trn,
    output logic [OP_W-1:0]  cdrv,
    output logic [ACC_W-1:0] acc,
    output logic [OP_W-1:0]  trn
);
    localparam bit LOWER = (ROW >= COL);
    localparam bit DIAG  = (ROW == COL);

    typedef struct packed {
        logic [OP_W-1:0]  opnd;
        logic [ACC_W-1:0] acc;
        logic [OP_W-1:0]  trn;
    } pe_t;

    pe_t pe_d, pe_q;
    logic signed [2*OP_W-1:0] prod;

    always_comb begin
        pe_d = pe_q;
        prod = $signed(pe_q.opnd) * $signed(col_bus);
        if (ld_op) pe_d.opnd = row_bus;
        if (pl_we) begin
            pe_d.acc = pl_data;
        end else if (LOWER && upd) begin
            pe_d.acc = pe_q.acc + ACC_W'(prod);
        end
        if (clr_trn)      pe_d.trn = '0;
        else if (cap_trn) pe_d.trn = col_bus;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pe_q <= '0;
        else        pe_q <= pe_d;
    end

    generate
        if (DIAG) begin : g_diag
            assign cdrv = row_bus;
        end else begin : g_off
            assign cdrv = '0;
        end
    endgenerate

    assign acc = pe_q.acc;
    assign trn = pe_q.trn;
endmodule

// File: rtl/mesh_rank_update.sv
module mesh_rank_update
    import mesh_pkg::*;
#(
    parameter int N     = 4,
    parameter int OP_W  = 16,
    parameter int ACC_W = 40,
    parameter int K_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_valid,
    input  logic [$clog2(N*N)-1:0]   ld_index,
    input  logic [ACC_W-1:0]         ld_value,
    input  logic                     go,
    input  logic [K_W-1:0]           num_cols,
    output logic                     busy,
    input  logic                     vec_valid,
    input  logic [N*OP_W-1:0]        vec_data,
    output logic                     done,
    output logic                     rd_valid,
    output logic [ACC_W-1:0]         rd_acc,
    output logic [OP_W-1:0]          rd_trn
);
    localparam int IDX_W = $clog2(N*N);
    localparam int CELLS = N*N;

    typedef struct packed {
        logic [N-1:0][OP_W-1:0] row;
        logic [N-1:0][OP_W-1:0] col;
    } bus_t;

    bus_t bus_d, bus_q;

    logic             accept, stage1, stage2, clr_trn, load_en;
    logic [K_W-1:0]   stage2_k;
    logic [IDX_W-1:0] rd_idx;

    logic [OP_W-1:0]  cdrv    [N][N];
    logic [ACC_W-1:0] acc_arr [CELLS];
    logic [OP_W-1:0]  trn_arr [CELLS];
    logic [CELLS*ACC_W-1:0] acc_flat;
    logic [N-1:0][OP_W-1:0] col_wire;

    mesh_ctrl #(.N(N), .K_W(K_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .num_cols (num_cols),
        .vec_valid(vec_valid),
        .accept   (accept),
        .stage1   (stage1),
        .stage2   (stage2),
        .stage2_k (stage2_k),
        .clr_trn  (clr_trn),
        .load_en  (load_en),
        .busy     (busy),
        .done     (done),
        .rd_valid (rd_valid),
        .rd_idx   (rd_idx)
    );

    // column buses: wired OR of all PEs in a column, only the diagonal drives
    always_comb begin
        for (int c = 0; c < N; c++) begin
            col_wire[c] = '0;
            for (int r = 0; r < N; r++) col_wire[c] = col_wire[c] | cdrv[r][c];
        end
    end

    always_comb begin
        bus_d = bus_q;
        if (accept) begin
            for (int r = 0; r < N; r++) bus_d.row[r] = vec_data[r*OP_W +: OP_W];
        end
        if (stage1) bus_d.col = col_wire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    generate
        for (genvar r = 0; r < N; r++) begin : g_row
            for (genvar c = 0; c < N; c++) begin : g_col
                localparam int CELL = r*N + c;
                logic pl_we_w, cap_w;
                assign pl_we_w = ld_valid && load_en && (ld_index == IDX_W'(CELL));
                assign cap_w   = stage2 && (stage2_k == K_W'(r));
                mesh_pe #(.OP_W(OP_W), .ACC_W(ACC_W), .ROW(r), .COL(c)) u_pe (
                    .clk    (clk),
                    .rst_n  (rst_n),
                    .pl_we  (pl_we_w),
                    .pl_data(ld_value),
                    .clr_trn(clr_trn),
                    .ld_op  (stage1),
                    .row_bus(bus_q.row[r]),
                    .col_bus(bus_q.col[c]),
                    .upd    (stage2),
                    .cap_trn(cap_w),
                    .cdrv   (cdrv[r][c]),
                    .acc    (acc_arr[CELL]),
                    .trn    (trn_arr[CELL])
                );
                assign acc_flat[CELL*ACC_W +: ACC_W] = acc_arr[CELL];
            end
        end
    endgenerate

    assign rd_acc = rd_valid ? acc_arr[rd_idx] : '0;
    assign rd_trn = rd_valid ? trn_arr[rd_idx] : '0;
endmodule

// File: rtl/mesh_rank_update_chk.sv
module mesh_rank_update_chk #(
    parameter int N     = 4,
    parameter int ACC_W = 40
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   busy,
    input logic                   done,
    input logic                   rd_valid,
    input logic [N*N*ACC_W-1:0]   acc_flat
);
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    done_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rd_valid);
    // R6
    readout_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !done) |-> $past(rd_valid));
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_valid);

    generate
        for (genvar r = 0; r < N; r++) begin : g_r
            for (genvar c = r + 1; c < N; c++) begin : g_c
                // R4
                upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (busy && $past(busy)) |-> $stable(acc_flat[(r*N+c)*ACC_W +: ACC_W]));
            end
        end
    endgenerate
endmodule

bind mesh_rank_update mesh_rank_update_chk #(.N(N), .ACC_W(ACC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .rd_valid(rd_valid),
    .acc_flat(acc_flat)
);

// File: tb/mesh_rank_update_test.sv
module mesh_rank_update_test;
    localparam int N     = 4;
    localparam int OP_W  = 16;
    localparam int ACC_W = 40;
    localparam int K_W   = 8;
    localparam int IDX_W = $clog2(N*N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_valid = 1'b0;
    logic [IDX_W-1:0] ld_index = '0;
    logic [ACC_W-1:0] ld_value = '0;
    logic go = 1'b0;
    logic [K_W-1:0] num_cols = '0;
    logic busy;
    logic vec_valid = 1'b0;
    logic [N*OP_W-1:0] vec_data = '0;
    logic done, rd_valid;
    logic [ACC_W-1:0] rd_acc;
    logic [OP_W-1:0] rd_trn;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    longint cexp [N*N];
    longint texp [N*N];
    int     acol [16][N];

    always #10 clk = ~clk;

    mesh_rank_update #(.N(N), .OP_W(OP_W), .ACC_W(ACC_W), .K_W(K_W)) uut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_index(ld_index),
        .ld_value(ld_value), .go(go), .num_cols(num_cols), .busy(busy),
        .vec_valid(vec_valid), .vec_data(vec_data), .done(done),
        .rd_valid(rd_valid), .rd_acc(rd_acc), .rd_trn(rd_trn)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic int colval(int seed, int k, int r);
        return ((seed*53 + k*29 + r*71 + k*r*13) % 401) - 200;
    endfunction

    function automatic longint preval(int seed, int i);
        return longint'(((seed*97 + i*131) % 2001) - 1000) * 1000;
    endfunction

    // one full run: preload, stream, drain, readout and compare
    task automatic run_case(input int seed, input int kc, input bit gaps, input bit noisy);
        int cnt;
        for (int i = 0; i < N*N; i++) begin
            @(negedge clk);
            ld_valid = 1'b1; ld_index = IDX_W'(i); ld_value = ACC_W'(preval(seed, i));
            cexp[i] = preval(seed, i);
        end
        for (int k = 0; k < kc; k++)
            for (int r = 0; r < N; r++) acol[k][r] = colval(seed, k, r);
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                texp[r*N+c] = (r < kc) ? longint'(acol[r][c]) : 0;
                if (r >= c)
                    for (int k = 0; k < kc; k++)
                        cexp[r*N+c] += longint'(acol[k][r]) * longint'(acol[k][c]);
            end
        @(negedge clk);
        ld_valid = 1'b0;
        if (noisy) begin
            // R7: vector offered while idle must be dropped
            vec_valid = 1'b1;
            for (int r = 0; r < N; r++) vec_data[r*OP_W +: OP_W] = OP_W'(777);
            @(negedge clk);
            vec_valid = 1'b0;
        end
        go = 1'b1; num_cols = K_W'(kc);
        @(negedge clk);
        go = 1'b0;
        chk(busy == 1'b1, "R9", "busy after start", longint'(busy), 1);
        for (int k = 0; k < kc; k++) begin
            if (gaps && (k % 2 == 1)) begin
                vec_valid = 1'b0;
                if (noisy) begin
                    // R7: load writes and a start request during a run are ignored
                    ld_valid = 1'b1; ld_index = IDX_W'((k % 2 == 1) ? 0 : 3);
                    ld_value = ACC_W'(123456);
                    go = 1'b1; num_cols = K_W'(1);
                end
                @(negedge clk);
                ld_valid = 1'b1; ld_index = IDX_W'(3); ld_value = ACC_W'(-5);
                ld_valid = noisy;
                go = 1'b0;
                @(negedge clk);
                ld_valid = 1'b0;
            end
            vec_valid = 1'b1;
            for (int r = 0; r < N; r++) vec_data[r*OP_W +: OP_W] = OP_W'(acol[k][r]);
            @(negedge clk);
            vec_valid = 1'b0;
        end
        cnt = 0;
        while (!done && cnt < 50) begin
            chk(rd_valid == 1'b0, "R6", "no readout before done", longint'(rd_valid), 0);
            @(negedge clk);
            cnt++;
        end
        if (kc > 0) chk(cnt == 3, "R6", "cycles last column to done", cnt, 3);
        for (int i = 0; i < N*N; i++) begin
            chk(rd_valid == 1'b1, "R6", "readout valid", longint'(rd_valid), 1);
            chk(done == (i == 0), "R6", "done on first element only", longint'(done), (i == 0));
            if ((i / N) >= (i % N))
                chk(longint'($signed(rd_acc)) == cexp[i], (kc == 0) ? "R2" : (gaps ? "R8" : "R3"),
                    $sformatf("lower element %0d", i), longint'($signed(rd_acc)), cexp[i]);
            else
                chk(longint'($signed(rd_acc)) == cexp[i], noisy ? "R7" : "R4",
                    $sformatf("upper element %0d", i), longint'($signed(rd_acc)), cexp[i]);
            chk(longint'($signed(rd_trn)) == texp[i], "R5", $sformatf("transpose %0d", i),
                longint'($signed(rd_trn)), texp[i]);
            @(negedge clk);
        end
        chk(rd_valid == 1'b0, "R6", "readout ends after N*N", longint'(rd_valid), 0);
        chk(busy == 1'b0, "R9", "busy falls after readout", longint'(busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            bad++; total++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(busy == 1'b0, "R1", "busy in reset", longint'(busy), 0);
        chk(done == 1'b0, "R1", "done in reset", longint'(done), 0);
        chk(rd_valid == 1'b0, "R1", "rd_valid in reset", longint'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy after reset", longint'(busy), 0);

        run_case(1, 0, 1'b0, 1'b0);   // R2: preload only
        run_case(2, 4, 1'b0, 1'b0);   // R3, R4, R5: back-to-back columns
        run_case(3, 6, 1'b1, 1'b1);   // R7, R8: stalls and stray requests
        run_case(4, 2, 1'b0, 1'b0);   // R5: short run leaves rows 2..3 cleared
        run_case(5, 9, 1'b1, 1'b0);   // R8: long run with stalls

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule